// File: doc/BRIEF.md
# Supertiled Surface Address Generator

This block turns a pixel coordinate and a surface description into the byte offset of that pixel inside a tiled render surface. Two layouts are supported. In the plain tiled layout, pixels are grouped in 4x4 tiles. Tiles sit one after another along a tile row, and a programmable stride separates successive tile rows. In the supertiled layout, those same 4x4 tiles are themselves grouped into 64x64-pixel supertiles. Inside a supertile the tiles are interleaved in blocks of two tile columns by four tile rows. Surfaces in this layout are padded to a width that is a multiple of 64 pixels.

A request either converts one coordinate or walks a rectangle. A walk starts at an origin and covers a width and height, and it produces one offset per clock in raster order: across a row first, then down to the next row. Every offset is registered and qualified by `out_valid`. `out_last` marks the final offset of a request.

The control is a two-state machine.
- **WK_IDLE**: the block accepts requests. A single-pixel conversion, or a walk of exactly one pixel, completes from WK_IDLE without leaving it.
- **Transition WK_IDLE to WK_RUN**: taken when a walk covering more than one pixel is accepted.
- **WK_RUN**: the block emits the remaining pixels of the walk and ignores new requests.
- **Transition WK_RUN to WK_IDLE**: taken on the cycle the final pixel is issued.

Top module: `surf_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `busy` are 0.
- R2: A request accepted in WK_IDLE with `req_walk`=0 gives `out_valid`=1 and `out_last`=1 on the next cycle, carrying the offset of (`req_x`,`req_y`).
- R3: With `req_layout`=0 (tiled), offset = floor(y/4)*stride + floor(x/4)*16*B + ((y mod 4)*4 + (x mod 4))*B, where B is the byte size from R5.
- R4: With `req_layout`=1 (supertiled), let tx=floor(x/4) mod 16 and ty=floor(y/4) mod 16, and let tile = floor(ty/4)*64 + floor(tx/2)*8 + (ty mod 4)*2 + (tx mod 2). Then offset = floor(y/64)*stride*16 + floor(x/64)*4096*B + tile*16*B + ((y mod 4)*4 + (x mod 4))*B.
- R5: `req_bpp` encodes the pixel size B: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
- R6: A walk request (`req_walk`=1) with width W>0 and height H>0 produces W*H offsets on consecutive cycles. The first appears on the cycle after acceptance. The order is x from `req_x` to `req_x`+W-1 within each row, rows from `req_y` downward. `busy` is 1 while offsets remain to be issued.
- R7: `out_last` is 1 only with the final offset of a request. On the cycle after that offset, `out_valid` is 0 unless a new request was accepted.
- R8: A walk request with W=0 or H=0 produces no output and leaves the block in WK_IDLE.
- R9: Requests presented while `busy`=1 are ignored. A running walk keeps the origin, size, layout, pixel size and stride captured when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken in WK_IDLE |
| req_walk | input | 1 | 0 = single pixel, 1 = rectangle walk |
| req_layout | input | 1 | 0 = 4x4 tiled, 1 = 64x64 supertiled |
| req_bpp | input | 2 | Pixel size code (R5) |
| req_stride | input | SW (20) | Bytes from one tile row to the next |
| req_x | input | CW (12) | Pixel column, or walk origin column |
| req_y | input | CW (12) | Pixel row, or walk origin row |
| req_w | input | CW (12) | Walk width in pixels |
| req_h | input | CW (12) | Walk height in pixels |
| busy | output | 1 | Walk in progress (WK_RUN) |
| out_valid | output | 1 | Offset valid |
| out_last | output | 1 | Final offset of the request |
| out_offset | output | AW (32) | Byte offset |

## Verification
The hardest cases to reach are the supertile boundaries. Offsets only show the interleaved tile pattern, and the jumps between supertiles and supertile rows, once a coordinate crosses multiples of 8, 16 and 64. The stimulus reaches all of them by walking a full 128x128 surface, four supertiles, in every layout and pixel size, and comparing each offset against an arithmetic model. A second hard case is a request arriving in the middle of a walk. A junk request is pulsed mid-walk, and the following offsets are checked to confirm that the captured parameters still apply.

// File: rtl/surf_addr_pkg.sv
package surf_addr_pkg;

    typedef enum logic {
        LAYOUT_TILED = 1'b0,
        LAYOUT_SUPER = 1'b1
    } layout_e;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_RUN  = 1'b1
    } walk_state_e;

    // log2 of the pixel size in bytes; codes 2 and 3 both select 4 bytes
    function automatic logic [1:0] bpp_shift(input logic [1:0] code);
        logic [1:0] sh;
        unique case (code)
            2'd0:    sh = 2'd0;
            2'd1:    sh = 2'd1;
            default: sh = 2'd2;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/surf_tile_index.sv
// Pixel position inside a 4x4 tile and tile position inside a 64x64 supertile.
module surf_tile_index (
    input  logic [5:0] x_lo,
    input  logic [5:0] y_lo,
    output logic [3:0] pix_idx,
    output logic [7:0] tile_idx
);
    logic [3:0] tx;
    logic [3:0] ty;

    always_comb begin
        tx       = x_lo[5:2];
        ty       = y_lo[5:2];
        pix_idx  = {y_lo[1:0], x_lo[1:0]};
        // band of 4 tile rows, 2-column group, row in group, column in group
        tile_idx = {ty[3:2], tx[3:1], ty[1:0], tx[0]};
    end
endmodule

// File: rtl/surf_offset_calc.sv
module surf_offset_calc
    import surf_addr_pkg::*;
#(
    parameter int CW = 12,
    parameter int SW = 20,
    parameter int AW = 32
) (
    input  layout_e         layout,
    input  logic [1:0]      bpp_code,
    input  logic [SW-1:0]   stride,
    input  logic [CW-1:0]   px,
    input  logic [CW-1:0]   py,
    output logic [AW-1:0]   offset
);
    localparam int TILE_SH  = 2;   // 4 pixels per tile edge
    localparam int SUPER_SH = 6;   // 64 pixels per supertile edge

    logic [3:0]    pix_idx;
    logic [7:0]    tile_idx;
    logic [1:0]    bsh;
    logic [AW-1:0] pix_term;
    logic [AW-1:0] tiled_off;
    logic [AW-1:0] super_off;

    surf_tile_index u_idx (
        .x_lo     (px[5:0]),
        .y_lo     (py[5:0]),
        .pix_idx  (pix_idx),
        .tile_idx (tile_idx)
    );

    always_comb begin
        bsh       = bpp_shift(bpp_code);
        pix_term  = AW'(pix_idx) << bsh;
        tiled_off = AW'(py >> TILE_SH) * AW'(stride)
                  + (AW'(px >> TILE_SH) << (4 + bsh))
                  + pix_term;
        super_off = ((AW'(py >> SUPER_SH) * AW'(stride)) << 4)
                  + (AW'(px >> SUPER_SH) << (12 + bsh))
                  + (AW'(tile_idx) << (4 + bsh))
                  + pix_term;
        offset    = (layout == LAYOUT_SUPER) ? super_off : tiled_off;
    end
endmodule

// File: rtl/surf_walker.sv
module surf_walker
    import surf_addr_pkg::*;
#(
    parameter int CW = 12,
    parameter int SW = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_walk,
    input  layout_e        req_layout,
    input  logic [1:0]     req_bpp,
    input  logic [SW-1:0]  req_stride,
    input  logic [CW-1:0]  req_x,
    input  logic [CW-1:0]  req_y,
    input  logic [CW-1:0]  req_w,
    input  logic [CW-1:0]  req_h,
    output logic           pt_fire,
    output logic           pt_last,
    output logic [CW-1:0]  pt_x,
    output logic [CW-1:0]  pt_y,
    output layout_e        pt_layout,
    output logic [1:0]     pt_bpp,
    output logic [SW-1:0]  pt_stride,
    output logic           busy
);
    walk_state_e   state, state_nxt;

    logic [CW-1:0] cur_x, cur_y, org_x, end_x, end_y;
    layout_e       lay_q;
    logic [1:0]    bpp_q;
    logic [SW-1:0] stride_q;

    logic [CW-1:0] req_xe, req_ye;
    logic          req_empty, req_one;
    logic          accept_walk;
    logic [CW-1:0] ref_org, ref_end;
    logic [CW-1:0] adv_x, adv_y;

    always_comb begin
        req_xe      = req_x + req_w - CW'(1);
        req_ye      = req_y + req_h - CW'(1);
        req_empty   = (req_w == '0) || (req_h == '0);
        req_one     = (req_w == CW'(1)) && (req_h == CW'(1));
        accept_walk = 1'b0;
        state_nxt   = state;
        unique case (state)
            WK_IDLE: begin
                pt_x      = req_x;
                pt_y      = req_y;
                pt_layout = req_layout;
                pt_bpp    = req_bpp;
                pt_stride = req_stride;
                pt_fire   = req_valid && !(req_walk && req_empty);
                pt_last   = !req_walk || req_one;
                busy      = 1'b0;
                ref_org   = req_x;
                ref_end   = req_xe;
                if (req_valid && req_walk && !req_empty && !req_one) begin
                    accept_walk = 1'b1;
                    state_nxt   = WK_RUN;
                end
            end
            WK_RUN: begin
                pt_x      = cur_x;
                pt_y      = cur_y;
                pt_layout = lay_q;
                pt_bpp    = bpp_q;
                pt_stride = stride_q;
                pt_fire   = 1'b1;
                pt_last   = (cur_x == end_x) && (cur_y == end_y);
                busy      = 1'b1;
                ref_org   = org_x;
                ref_end   = end_x;
                if (pt_last) begin
                    state_nxt = WK_IDLE;
                end
            end
        endcase
        // raster step: wrap to the origin column at the row end
        if (pt_x == ref_end) begin
            adv_x = ref_org;
            adv_y = pt_y + CW'(1);
        end else begin
            adv_x = pt_x + CW'(1);
            adv_y = pt_y;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WK_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x    <= '0;
            cur_y    <= '0;
            org_x    <= '0;
            end_x    <= '0;
            end_y    <= '0;
            lay_q    <= LAYOUT_TILED;
            bpp_q    <= '0;
            stride_q <= '0;
        end else if (accept_walk) begin
            cur_x    <= adv_x;
            cur_y    <= adv_y;
            org_x    <= req_x;
            end_x    <= req_xe;
            end_y    <= req_ye;
            lay_q    <= req_layout;
            bpp_q    <= req_bpp;
            stride_q <= req_stride;
        end else if (state == WK_RUN && !pt_last) begin
            cur_x    <= adv_x;
            cur_y    <= adv_y;
        end
    end
endmodule

// File: rtl/surf_addr_gen.sv
module surf_addr_gen
    import surf_addr_pkg::*;
#(
    parameter int CW = 12,
    parameter int SW = 20,
    parameter int AW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_walk,
    input  logic           req_layout,
    input  logic [1:0]     req_bpp,
    input  logic [SW-1:0]  req_stride,
    input  logic [CW-1:0]  req_x,
    input  logic [CW-1:0]  req_y,
    input  logic [CW-1:0]  req_w,
    input  logic [CW-1:0]  req_h,
    output logic           busy,
    output logic           out_valid,
    output logic           out_last,
    output logic [AW-1:0]  out_offset
);
    logic          pt_fire, pt_last;
    logic [CW-1:0] pt_x, pt_y;
    layout_e       pt_layout;
    logic [1:0]    pt_bpp;
    logic [SW-1:0] pt_stride;
    logic [AW-1:0] calc_off;

    surf_walker #(.CW(CW), .SW(SW)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_walk   (req_walk),
        .req_layout (layout_e'(req_layout)),
        .req_bpp    (req_bpp),
        .req_stride (req_stride),
        .req_x      (req_x),
        .req_y      (req_y),
        .req_w      (req_w),
        .req_h      (req_h),
        .pt_fire    (pt_fire),
        .pt_last    (pt_last),
        .pt_x       (pt_x),
        .pt_y       (pt_y),
        .pt_layout  (pt_layout),
        .pt_bpp     (pt_bpp),
        .pt_stride  (pt_stride),
        .busy       (busy)
    );

    surf_offset_calc #(.CW(CW), .SW(SW), .AW(AW)) u_calc (
        .layout   (pt_layout),
        .bpp_code (pt_bpp),
        .stride   (pt_stride),
        .px       (pt_x),
        .py       (pt_y),
        .offset   (calc_off)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            out_offset <= '0;
        end else begin
            out_valid <= pt_fire;
            out_last  <= pt_fire && pt_last;
            if (pt_fire) begin
                out_offset <= calc_off;
            end
        end
    end
endmodule

// File: rtl/surf_addr_gen_chk.sv
module surf_addr_gen_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_walk,
    input logic [CW-1:0] req_w,
    input logic [CW-1:0] req_h,
    input logic          busy,
    input logic          out_valid,
    input logic          out_last
);
    a_r7_last_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    a_r2_single_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_walk && !busy) |=> (out_valid && out_last));

    a_r6_busy_streams: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> out_valid);

    a_r6_walk_enters_run: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_walk && !busy && req_w > 1) && req_h != 0 |=> busy);

    a_r7_last_leaves_run: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> !busy);

    a_r8_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_walk && !busy && (req_w == 0 || req_h == 0)) |=> (!out_valid && !busy));
endmodule

bind surf_addr_gen surf_addr_gen_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_walk  (req_walk),
    .req_w     (req_w),
    .req_h     (req_h),
    .busy      (busy),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/surf_addr_gen_bench.sv
module surf_addr_gen_bench;
    localparam int CW = 12;
    localparam int SW = 20;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_walk = 1'b0;
    logic          req_layout = 1'b0;
    logic [1:0]    req_bpp = '0;
    logic [SW-1:0] req_stride = '0;
    logic [CW-1:0] req_x = '0, req_y = '0, req_w = '0, req_h = '0;
    logic          busy, out_valid, out_last;
    logic [AW-1:0] out_offset;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    surf_addr_gen #(.CW(CW), .SW(SW), .AW(AW)) u_surf_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_walk(req_walk),
        .req_layout(req_layout), .req_bpp(req_bpp), .req_stride(req_stride),
        .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h),
        .busy(busy), .out_valid(out_valid), .out_last(out_last), .out_offset(out_offset)
    );

    function automatic longint bytes_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    function automatic longint model(input int lay, input int code, input longint st,
                                     input longint x, input longint y);
        longint b, pix, tx, ty, t;
        b   = bytes_of(code);
        pix = (y % 4) * 4 + (x % 4);
        if (lay == 0) return (y / 4) * st + (x / 4) * 16 * b + pix * b;
        tx = (x / 4) % 16;
        ty = (y / 4) % 16;
        t  = (ty / 4) * 64 + (tx / 2) * 8 + (ty % 4) * 2 + (tx % 2);
        return ((y / 64) * st * 16 + (x / 64) * 4096 * b + t * 16 * b + pix * b) & 64'hFFFF_FFFF;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit walk, input int lay, input int code, input int st,
                         input int x, input int y, input int w, input int h);
        req_valid  = 1'b1;
        req_walk   = walk;
        req_layout = lay[0];
        req_bpp    = code[1:0];
        req_stride = SW'(st);
        req_x = CW'(x); req_y = CW'(y); req_w = CW'(w); req_h = CW'(h);
    endtask

    task automatic single(input string req, input int lay, input int code, input int st,
                          input int x, input int y);
        longint e;
        @(negedge clk);
        drive(1'b0, lay, code, st, x, y, 0, 0);
        @(negedge clk);
        req_valid = 1'b0;
        e = model(lay, code, st, x, y);
        check(out_valid && out_last, {req, " valid/last"}, {out_valid, out_last}, 2'b11);
        check(out_offset == AW'(e), {req, " offset"}, out_offset, e);
    endtask

    task automatic walk(input string req, input int lay, input int code, input int st,
                        input int x0, input int y0, input int w, input int h, input bit inject);
        int k = 0;
        bit ok_all = 1'b1;
        longint e;
        @(negedge clk);
        drive(1'b1, lay, code, st, x0, y0, w, h);
        @(negedge clk);
        for (int j = 0; j < h; j++) begin
            for (int i = 0; i < w; i++) begin
                bit fin = (j == h - 1) && (i == w - 1);
                e = model(lay, code, st, x0 + i, y0 + j);
                if (!(out_valid && out_offset == AW'(e) && out_last == fin)) begin
                    check(1'b0, {req, " walk offset (R6/R7)"}, out_offset, e);
                    ok_all = 1'b0;
                end
                if (inject && k == 3) drive(1'b1, lay ^ 1, 3, 7, 1, 1, 2, 2); // R9 junk
                else req_valid = 1'b0;
                k++;
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        check(ok_all, {req, " whole walk R6"}, ok_all, 1);
        check(!out_valid && !busy, {req, " idle after last R7"}, {out_valid, busy}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !out_last && !busy, "R1 reset", {out_valid, out_last, busy}, 0);
        rst_n = 1'b1;

        // R3 stride example: 512-wide, 4-byte pixels, stride 8192
        single("R3 tiled row", 0, 2, 8192, 0, 4);
        single("R3 tiled pix", 0, 2, 8192, 7, 6);
        // R4 tile interleave and supertile jumps, width 448 stride 0x1C00
        single("R4 tile1", 1, 2, 'h1C00, 4, 0);
        single("R4 tile2", 1, 2, 'h1C00, 0, 4);
        single("R4 tile8", 1, 2, 'h1C00, 8, 0);
        single("R4 tile64", 1, 2, 'h1C00, 0, 16);
        single("R4 next super col", 1, 2, 'h1C00, 64, 0);
        single("R4 next super row", 1, 2, 'h1C00, 0, 64);
        single("R4 far corner", 1, 1, 'h3400, 4095, 4095);
        single("R5 code3 is 4B", 1, 3, 'h3400, 37, 53);
        single("R5 code3 tiled", 0, 3, 8192, 13, 9);
        single("R2 single tiled 1B", 0, 0, 1024, 255, 3);

        // R8 empty rectangles
        @(negedge clk);
        drive(1'b1, 1, 2, 2048, 5, 5, 0, 4);
        @(negedge clk);
        req_valid = 1'b0;
        check(!out_valid && !busy, "R8 zero width", {out_valid, busy}, 0);
        drive(1'b1, 0, 2, 2048, 5, 5, 3, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check(!out_valid && !busy, "R8 zero height", {out_valid, busy}, 0);

        // R6/R7 small shapes
        walk("R7 one pixel", 1, 2, 2048, 9, 9, 1, 1, 1'b0);
        walk("R6 column", 1, 1, 2048, 3, 62, 1, 5, 1'b0);
        walk("R6 row", 0, 0, 512, 60, 3, 7, 1, 1'b0);
        walk("R9 odd rect inject", 1, 2, 'h1C00, 5, 61, 7, 9, 1'b1);

        // Exhaustive 128x128 surfaces, every layout and pixel size (R3, R4, R5)
        for (int lay = 0; lay < 2; lay++) begin
            for (int code = 0; code < 3; code++) begin
                int st = 128 * 4 * int'(bytes_of(code));
                walk(lay == 0 ? "R3 sweep" : "R4 sweep", lay, code, st, 0, 0, 128, 128, code == 1);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule